// File: doc/BRIEF.md
# Two-Overflow Watchdog Timer

This block is a watchdog peripheral reached over a 32-bit register port clocked by a bus clock. A free-running counter clocked by a separate oscillator clock measures a programmable timeout period. The period is `(setting + 1) << PRESCALE_LOG2` oscillator cycles. `setting` is a 12-bit field. With the default prescale of 20 bits, one step of the setting is 1,048,576 oscillator cycles.

The first expiry of the period raises an interrupt. Software keeps the system alive by writing the refresh register, which clears that interrupt and restarts the count. If a second expiry follows the first with no refresh in between, the block drives its active-low reset request low and holds it there until the block itself is reset.

Software can also pull the reset request at once through a forced-parity-error path. A control bit arms this path and a force bit fires it. Configuration registers live in the bus clock domain. Their effect crosses into the oscillator domain through two-stage synchronisers, so every write reaches the counter on the third oscillator edge after the bus edge that captured it.

Top module: `wdt_two_ovf`

## Requirements
- R1: After reset the register reads are as follows: control (0x00) reads 0, period (0x04) reads 0, elapsed (0x08) reads 0, status/refresh (0x0C) reads 0, parity control (0x10) reads 1 and parity force (0x14) reads 0. After reset `irq` is 0 and `wdt_rst_n` is 1.
- R2: The period setting occupies bits [31:20] of register 0x04. The lower 20 bits are dropped on write and read as 0. A write to 0x04 has no effect once the watchdog is enabled.
- R3: Writing 1 to bit 0 of 0x00 enables counting, and bit 0 of 0x00 reads back the enable. Once the enable is set, writing 0 leaves it set; only `rst_n` clears it.
- R4: With setting S, the counter expires after (S+1)·2^PRESCALE_LOG2 oscillator cycles of counting. The first expiry sets `irq`.
- R5: `wdt_rst_n` falls only on an expiry that occurs while `irq` is already set, or through the path of R8. Once low, it stays low until `rst_n`, even if a refresh is written.
- R6: Writing a value with bit 0 = 1 to 0x0C clears `irq` and restarts the count from zero. A write with bit 0 = 0 does nothing. Bit 0 of 0x0C reads `irq`.
- R7: Writing 0 to 0x08 restarts the count but leaves `irq` unchanged. A nonzero write to 0x08 does nothing. Register 0x08 always reads 0.
- R8: If bit 0 of 0x10 is 0 while bit 0 of 0x14 is 1, `wdt_rst_n` goes low. While bit 0 of 0x10 is 1, the force bit has no effect.
- R9: A register write captured on bus edge P acts on the third oscillator edge after P. This holds for the enable, the restart writes and the force path.
- R10: Asserting `rst_n` mid-operation clears the enable, the setting, the counter, `irq` and the reset request, and restores the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bus | input | 1 | Register port clock |
| clk_osc | input | 1 | Oscillator clock driving the counter |
| rst_n | input | 1 | Asynchronous active-low module reset |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | First-expiry interrupt, oscillator domain |
| wdt_rst_n | output | 1 | Active-low reset request, sticky until `rst_n` |

## Verification
The bench builds the block with `PRESCALE_LOG2 = 4`, so one setting step is 16 oscillator cycles instead of about a million. At this size the single expiry, the second expiry and refreshes that land between the two all fit in a few hundred cycles. Setting values 0 and 1 give periods of 16 and 32 cycles. These are short enough to refresh inside the window with margin, and long enough that a missed restart changes when the reset request falls. The two clocks share a period with a fixed phase offset, which makes the three-edge synchroniser delay exact. This lets the bench model predict `irq` and `wdt_rst_n` on every oscillator cycle.

// File: rtl/wdt_two_ovf.sv
module wdt_two_ovf #(
  parameter int ADDR_W        = 5,
  parameter int DATA_W        = 32,
  parameter int SET_W         = 12,
  parameter int PRESCALE_LOG2 = 20
) (
  input  logic              clk_bus,
  input  logic              clk_osc,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq,
  output logic              wdt_rst_n
);

  localparam int CNT_W    = SET_W + PRESCALE_LOG2;
  localparam int FIELD_LO = DATA_W - SET_W;

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_ELAP = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_PCTL = ADDR_W'(8'h10);
  localparam logic [ADDR_W-1:0] A_PFRC = ADDR_W'(8'h14);

  // bus clock domain
  logic             en_b, pctl_b, pfrc_b, ref_tgl, clr_tgl;
  logic [SET_W-1:0] per_b;
  logic [1:0]       irq_bs;

  wire wr    = bus_valid & bus_write;
  wire frc_b = pfrc_b & ~pctl_b;

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) begin
      en_b    <= 1'b0;
      per_b   <= '0;
      pctl_b  <= 1'b1;
      pfrc_b  <= 1'b0;
      ref_tgl <= 1'b0;
      clr_tgl <= 1'b0;
    end else if (wr) begin
      case (bus_addr)
        A_CTRL: if (bus_wdata[0]) en_b <= 1'b1;
        A_PER:  if (!en_b) per_b <= bus_wdata[DATA_W-1:FIELD_LO];
        A_ELAP: if (bus_wdata == '0) clr_tgl <= ~clr_tgl;
        A_STAT: if (bus_wdata[0]) ref_tgl <= ~ref_tgl;
        A_PCTL: pctl_b <= bus_wdata[0];
        A_PFRC: pfrc_b <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_bus or negedge rst_n) begin
    if (!rst_n) irq_bs <= '0;
    else        irq_bs <= {irq_bs[0], irq};
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[0] = en_b;
      A_PER:  bus_rdata[DATA_W-1:FIELD_LO] = per_b;
      A_STAT: bus_rdata[0] = irq_bs[1];
      A_PCTL: bus_rdata[0] = pctl_b;
      A_PFRC: bus_rdata[0] = pfrc_b;
      default: ;
    endcase
  end

  // oscillator clock domain
  logic [1:0]       en_s, frc_s;
  logic [2:0]       ref_s, clr_s;
  logic [SET_W-1:0] per_q;
  logic [CNT_W-1:0] cnt;
  logic             ovf, rst_req;

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      en_s  <= '0;
      frc_s <= '0;
      ref_s <= '0;
      clr_s <= '0;
    end else begin
      en_s  <= {en_s[0], en_b};
      frc_s <= {frc_s[0], frc_b};
      ref_s <= {ref_s[1:0], ref_tgl};
      clr_s <= {clr_s[1:0], clr_tgl};
    end
  end

  wire en_on     = en_s[1];
  wire frc_on    = frc_s[1];
  wire ref_pulse = ref_s[2] ^ ref_s[1];
  wire clr_pulse = clr_s[2] ^ clr_s[1];
  wire [CNT_W-1:0] period_last = {per_q, {PRESCALE_LOG2{1'b1}}};

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n)     per_q <= '0;
    else if (!en_on) per_q <= per_b;
  end

  always_ff @(posedge clk_osc or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      ovf     <= 1'b0;
      rst_req <= 1'b0;
    end else begin
      if (ref_pulse) begin
        cnt <= '0;
        ovf <= 1'b0;
      end else if (clr_pulse) begin
        cnt <= '0;
      end else if (en_on) begin
        if (cnt == period_last) begin
          cnt <= '0;
          if (ovf) rst_req <= 1'b1;
          else     ovf     <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
      if (frc_on) rst_req <= 1'b1;
    end
  end

  assign irq       = ovf;
  assign wdt_rst_n = ~rst_req;

  p_per_frozen_r2: assert property (@(posedge clk_bus) disable iff (!rst_n)
    en_b |=> $stable(per_b));
  p_en_sticky_r3: assert property (@(posedge clk_bus) disable iff (!rst_n)
    en_b |=> en_b);
  p_cnt_bound_r4: assert property (@(posedge clk_osc) disable iff (!rst_n)
    cnt <= period_last);
  p_rst_sticky_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    !wdt_rst_n |=> !wdt_rst_n);
  p_second_ovf_r5: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(wdt_rst_n) |-> ($past(irq) || $past(frc_on)));
  p_refresh_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    ref_pulse |=> (!irq && cnt == '0));
  p_irq_clear_r6: assert property (@(posedge clk_osc) disable iff (!rst_n)
    $fell(irq) |-> $past(ref_pulse));

endmodule

// File: tb/test_wdt_two_ovf.sv
module test_wdt_two_ovf;
  localparam int  CLK_PERIOD = 10;
  localparam int  HALF       = CLK_PERIOD / 2;
  localparam int  OSC_SKEW   = 3;
  localparam int  PL         = 4;
  localparam time LAT        = 3 * CLK_PERIOD + HALF + OSC_SKEW;

  logic        clk_bus = 1'b0, clk_osc = 1'b0, rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq, wdt_rst_n;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  wdt_two_ovf #(.PRESCALE_LOG2(PL)) i_wdt_two_ovf (
    .clk_bus(clk_bus), .clk_osc(clk_osc), .rst_n(rst_n),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .wdt_rst_n(wdt_rst_n));

  initial forever #(HALF) clk_bus = ~clk_bus;
  initial begin
    #(OSC_SKEW);
    forever begin
      clk_osc = ~clk_osc;
      #(HALF);
    end
  end

  // reference model state
  bit  m_en_b, m_pctl, m_pfrc, m_frc_sent;
  int  m_set_b;
  bit  m_en, m_flag, m_rst;
  int  m_cnt, m_per;
  time q_en[$], q_ref[$], q_clr[$], q_frc[$];
  bit  do_en, do_ref, do_clr, do_frc;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                     input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk_osc) begin
    if (!rst_n) begin
      m_en = 0; m_flag = 0; m_rst = 0; m_cnt = 0; m_per = 1 << PL;
    end else begin
      do_en  = (q_en.size()  > 0 && q_en[0]  == $time);
      do_ref = (q_ref.size() > 0 && q_ref[0] == $time);
      do_clr = (q_clr.size() > 0 && q_clr[0] == $time);
      do_frc = (q_frc.size() > 0 && q_frc[0] == $time);
      if (do_en)  void'(q_en.pop_front());
      if (do_ref) void'(q_ref.pop_front());
      if (do_clr) void'(q_clr.pop_front());
      if (do_frc) void'(q_frc.pop_front());
      if (do_en) begin
        m_en  = 1;
        m_per = (m_set_b + 1) << PL;
      end
      if (do_ref) begin
        m_cnt = 0; m_flag = 0;
      end else if (do_clr) begin
        m_cnt = 0;
      end else if (m_en) begin
        if (m_cnt == m_per - 1) begin
          m_cnt = 0;
          if (m_flag) m_rst = 1; else m_flag = 1;
        end else m_cnt++;
      end
      if (do_frc) m_rst = 1;
      chk("R4", {31'b0, irq}, {31'b0, m_flag}, "irq per cycle");
      chk("R5", {31'b0, wdt_rst_n}, {31'b0, !m_rst}, "wdt_rst_n per cycle");
    end
  end

  task automatic model_wr(input logic [4:0] a, input logic [31:0] d, input time t);
    case (a)
      5'h00: if (d[0] && !m_en_b) begin m_en_b = 1; q_en.push_back(t + LAT); end
      5'h04: if (!m_en_b) m_set_b = int'(d[31:20]);
      5'h08: if (d == 0) q_clr.push_back(t + LAT);
      5'h0C: if (d[0]) q_ref.push_back(t + LAT);
      5'h10: m_pctl = d[0];
      5'h14: m_pfrc = d[0];
      default: ;
    endcase
    if (m_pfrc && !m_pctl && !m_frc_sent) begin
      m_frc_sent = 1;
      q_frc.push_back(t + LAT);
    end
  endtask

  task automatic bus_wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk_bus);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    model_wr(a, d, $time);
    @(negedge clk_bus);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd_chk(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_bus);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    #1;
    chk(req, bus_rdata, exp, $sformatf("read 0x%0h", a));
    bus_valid = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_bus);
  endtask

  task automatic do_reset();
    @(negedge clk_bus);
    rst_n = 0;
    m_en_b = 0; m_pctl = 1; m_pfrc = 0; m_frc_sent = 0; m_set_b = 0;
    q_en.delete(); q_ref.delete(); q_clr.delete(); q_frc.delete();
    idle(2);
    rst_n = 1;
    idle(1);
  endtask

  task automatic chk_reset_state(input string req);
    rd_chk(5'h00, 32'h0, req);
    rd_chk(5'h04, 32'h0, req);
    rd_chk(5'h08, 32'h0, req);
    rd_chk(5'h0C, 32'h0, req);
    rd_chk(5'h10, 32'h1, req);
    rd_chk(5'h14, 32'h0, req);
    chk(req, {31'b0, irq}, 32'h0, "irq after reset");
    chk(req, {31'b0, wdt_rst_n}, 32'h1, "wdt_rst_n after reset");
  endtask

  initial begin
    do_reset();
    chk_reset_state("R1");

    // period field and freezing (R2), sticky enable (R3), two expiries (R4, R5)
    bus_wr(5'h04, 32'hABCF_FFFF);
    rd_chk(5'h04, 32'hABC0_0000, "R2");
    bus_wr(5'h04, 32'h0010_0000);
    bus_wr(5'h00, 32'h1);
    rd_chk(5'h00, 32'h1, "R3");
    bus_wr(5'h00, 32'h0);
    rd_chk(5'h00, 32'h1, "R3");
    bus_wr(5'h04, 32'h0050_0000);
    rd_chk(5'h04, 32'h0010_0000, "R2");
    idle(80);
    chk("R5", {31'b0, wdt_rst_n}, 32'h0, "reset after second expiry");
    rd_chk(5'h0C, 32'h1, "R6");
    bus_wr(5'h0C, 32'h1);
    idle(10);
    chk("R5", {31'b0, wdt_rst_n}, 32'h0, "reset request sticky over refresh");

    do_reset();
    chk_reset_state("R10");

    // refresh keeps alive, and clears the interrupt between expiries (R6)
    bus_wr(5'h04, 32'h0010_0000);
    bus_wr(5'h00, 32'h1);
    for (int k = 0; k < 10; k++) begin
      bus_wr(5'h0C, 32'h1);
      idle(3);
    end
    chk("R6", {31'b0, irq}, 32'h0, "irq held off by refresh");
    bus_wr(5'h0C, 32'h0);
    idle(40);
    chk("R4", {31'b0, irq}, 32'h1, "irq after first expiry");
    chk("R5", {31'b0, wdt_rst_n}, 32'h1, "no reset after one expiry");
    bus_wr(5'h0C, 32'h1);
    idle(6);
    chk("R6", {31'b0, irq}, 32'h0, "irq cleared by refresh");
    chk("R6", {31'b0, wdt_rst_n}, 32'h1, "refresh averts reset");
    idle(100);
    chk("R5", {31'b0, wdt_rst_n}, 32'h0, "reset after unrefreshed expiries");

    do_reset();

    // elapsed clear (R7)
    bus_wr(5'h04, 32'h0010_0000);
    bus_wr(5'h00, 32'h1);
    for (int k = 0; k < 10; k++) begin
      bus_wr(5'h08, 32'h0);
      idle(3);
    end
    chk("R7", {31'b0, irq}, 32'h0, "irq held off by elapsed clear");
    bus_wr(5'h08, 32'h5);
    idle(34);
    chk("R7", {31'b0, irq}, 32'h1, "nonzero elapsed write ignored");
    bus_wr(5'h08, 32'h0);
    idle(4);
    chk("R7", {31'b0, irq}, 32'h1, "elapsed clear keeps irq");
    rd_chk(5'h08, 32'h0, "R7");
    idle(27);
    chk("R7", {31'b0, wdt_rst_n}, 32'h1, "elapsed clear delays second expiry");
    idle(30);
    chk("R5", {31'b0, wdt_rst_n}, 32'h0, "reset after delayed second expiry");

    do_reset();

    // force path blocked while control bit is 1 (R8)
    bus_wr(5'h14, 32'h1);
    rd_chk(5'h14, 32'h1, "R8");
    idle(10);
    chk("R8", {31'b0, wdt_rst_n}, 32'h1, "force blocked by control");

    do_reset();
    chk_reset_state("R10");

    // force path latency (R8, R9)
    bus_wr(5'h10, 32'h0);
    idle(2);
    bus_wr(5'h14, 32'h1);
    #(CLK_PERIOD + HALF);
    chk("R9", {31'b0, wdt_rst_n}, 32'h1, "before third oscillator edge");
    #(CLK_PERIOD);
    chk("R9", {31'b0, wdt_rst_n}, 32'h0, "at third oscillator edge");
    idle(5);
    chk("R8", {31'b0, wdt_rst_n}, 32'h0, "forced reset held");

    do_reset();
    chk_reset_state("R10");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      failures++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule